// File: doc/BRIEF.md
# Fetch Address and Bus Source Controller

This block is the glue between the microsequencer's control word and the main datapath. It holds the program counter, chooses whether memory is addressed by the memory address register or by the program counter, selects which source drives the shared data bus, and raises the memory select, read and write strobes. The memory array, the ALU and the other registers sit outside. Their values arrive as inputs and the block returns the bus value and the memory control.

The program counter is an ordinary microcoded register. Its enable bit and the shared register-function field can load it from the bus, clear it, step it up or step it down. It also has an asynchronous clear tied to reset, so that after reset the first instruction fetch reads address 0.

One of the bus sources is a masked copy of the memory read data. It keeps only the low bits of the word, so the operand field of an instruction can go straight onto the bus. Every pin is a plain level signal that applies within a cycle. There is no valid/ready handshake, because both the bus and the memory port are driven combinationally from the current control word and have no back-pressure.

Top module: `fetch_bus_ctrl`

## Requirements
- R1: While `rst` is high the program counter reads 0 at once, without waiting for a clock edge. After release, a fetch addresses location 0.
- R2: `mem_addr` equals the program counter when control bit 19 (fetch) is 1. Otherwise it equals `mar_val`.
- R3: Control bits 7:5 select the bus value: 0 external input, 1 memory read data, 2 MAR, 3 program counter, 4 B, 5 ACC.
- R4: Source code 6 places the memory read data on the bus with bits 11:8 forced to 0 and bits 7:0 passed unchanged.
- R5: Source code 7 drives 0 onto the bus.
- R6: When control bit 2 (program counter enable) is 1, a rising clock applies the function in bits 13:12 to the program counter: 0 load from bus bits 11:0, 1 clear, 2 add one, 3 subtract one.
- R7: Add-one and subtract-one wrap modulo 4096 (0xFFF+1 gives 0, 0-1 gives 0xFFF).
- R8: When bit 2 is 0 the program counter keeps its value, whatever the function field holds and whatever enables bits 4, 3, 1 and 0 hold.
- R9: `mem_rd` and `mem_sel` are 1 when the fetch bit is set or the source is 1 or 6. Otherwise `mem_rd` is 0.
- R10: `mem_wr` is 1 exactly when bit 0 (memory enable) is 1 and no read kind from R9 is active. `mem_sel` is then 1, and `mem_wr` and `mem_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high reset, asynchronously clears the program counter |
| uinst | input | 32 | Current microinstruction word |
| ext_in | input | 12 | External input data |
| mem_rdata | input | 12 | Memory read data |
| mar_val | input | 12 | Memory address register value |
| acc_val | input | 12 | Accumulator value |
| b_val | input | 12 | B register value |
| mem_addr | output | 12 | Memory address |
| mem_sel | output | 1 | Memory select |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| bus_val | output | 12 | Shared data bus value |

## Verification
The bench builds the block with its defaults: 12-bit data and addresses and an 8-bit operand field. A 12-bit counter puts both wrap points (0xFFF to 0 and back) a single load and one step away. The masked source then clears exactly four upper bits, so a memory word with all upper bits set shows at once whether the mask is in place. Directed sequences cover each function and each source. A long run of random control words follows, in which the function field, the other register enables and the memory enable are mixed freely against a behavioural model of the program counter.

// File: rtl/fab_pkg.sv
package fab_pkg;

  localparam int CW_W       = 32;
  localparam int FETCH_BIT  = 19;
  localparam int FN_LO      = 12;
  localparam int SRC_LO     = 5;
  localparam int EN_ACC_BIT = 4;
  localparam int EN_B_BIT   = 3;
  localparam int EN_PC_BIT  = 2;
  localparam int EN_MAR_BIT = 1;
  localparam int EN_MEM_BIT = 0;

  typedef enum logic [2:0] {
    SRC_EXT   = 3'd0,
    SRC_MEM   = 3'd1,
    SRC_MAR   = 3'd2,
    SRC_PC    = 3'd3,
    SRC_B     = 3'd4,
    SRC_ACC   = 3'd5,
    SRC_MEMLO = 3'd6,
    SRC_NONE  = 3'd7
  } bus_src_e;

  typedef enum logic [1:0] {
    FN_LOAD  = 2'd0,
    FN_CLEAR = 2'd1,
    FN_INC   = 2'd2,
    FN_DEC   = 2'd3
  } reg_fn_e;

  typedef struct packed {
    logic     fetch;
    bus_src_e src;
    reg_fn_e  fn;
    logic     en_pc;
    logic     en_mem;
  } ctl_t;

  function automatic ctl_t split_word(input logic [CW_W-1:0] w);
    ctl_t c;
    c.fetch  = w[FETCH_BIT];
    c.src    = bus_src_e'(w[SRC_LO +: 3]);
    c.fn     = reg_fn_e'(w[FN_LO +: 2]);
    c.en_pc  = w[EN_PC_BIT];
    c.en_mem = w[EN_MEM_BIT];
    return c;
  endfunction

endpackage

// File: rtl/fab_pc_reg.sv
module fab_pc_reg
  import fab_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  reg_fn_e           fn,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] pc_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_next;

  always_comb begin
    unique case (fn)
      FN_LOAD:  pc_next = bus_in[ADDR_W-1:0];
      FN_CLEAR: pc_next = '0;
      FN_INC:   pc_next = pc_q + ONE;
      FN_DEC:   pc_next = pc_q - ONE;
      default:  pc_next = pc_q;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     pc_q <= '0;
    else if (en) pc_q <= pc_next;
  end

endmodule

// File: rtl/fab_bus_mux.sv
module fab_bus_mux
  import fab_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int LOW_W  = 8
) (
  input  bus_src_e          src,
  input  logic [DATA_W-1:0] ext_in,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] mar_val,
  input  logic [ADDR_W-1:0] pc_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [DATA_W-1:0] acc_val,
  output logic [DATA_W-1:0] bus_out
);

  logic [DATA_W-1:0] mem_low;
  logic [DATA_W-1:0] mar_wide;
  logic [DATA_W-1:0] pc_wide;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi < LOW_W) begin : g_keep
        assign mem_low[gi] = mem_rdata[gi];
      end else begin : g_drop
        assign mem_low[gi] = 1'b0;
      end
    end
    if (ADDR_W == DATA_W) begin : g_same
      assign mar_wide = mar_val;
      assign pc_wide  = pc_val;
    end else begin : g_pad
      assign mar_wide = {{(DATA_W-ADDR_W){1'b0}}, mar_val};
      assign pc_wide  = {{(DATA_W-ADDR_W){1'b0}}, pc_val};
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_EXT:   bus_out = ext_in;
      SRC_MEM:   bus_out = mem_rdata;
      SRC_MAR:   bus_out = mar_wide;
      SRC_PC:    bus_out = pc_wide;
      SRC_B:     bus_out = b_val;
      SRC_ACC:   bus_out = acc_val;
      SRC_MEMLO: bus_out = mem_low;
      default:   bus_out = '0;
    endcase
  end

endmodule

// File: rtl/fab_mem_ctl.sv
module fab_mem_ctl
  import fab_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              fetch,
  input  bus_src_e          src,
  input  logic              en_mem,
  input  logic [ADDR_W-1:0] mar_val,
  input  logic [ADDR_W-1:0] pc_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel,
  output logic              mem_rd,
  output logic              mem_wr
);

  logic plain_rd;
  logic low_rd;

  assign plain_rd = (src == SRC_MEM);
  assign low_rd   = (src == SRC_MEMLO);
  assign mem_rd   = fetch | plain_rd | low_rd;
  assign mem_wr   = en_mem & ~mem_rd;
  assign mem_sel  = mem_rd | mem_wr;
  assign mem_addr = fetch ? pc_val : mar_val;

endmodule

// File: rtl/fetch_bus_ctrl.sv
module fetch_bus_ctrl
  import fab_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   uinst,
  input  logic [DATA_W-1:0] ext_in,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] mar_val,
  input  logic [DATA_W-1:0] acc_val,
  input  logic [DATA_W-1:0] b_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] bus_val
);

  ctl_t              ctl;
  logic [ADDR_W-1:0] pc_q;
  logic              spare_bits_unused;

  assign ctl = split_word(uinst);
  assign spare_bits_unused = ^uinst;

  fab_pc_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .en     (ctl.en_pc),
    .fn     (ctl.fn),
    .bus_in (bus_val),
    .pc_q   (pc_q)
  );

  fab_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_mux (
    .src       (ctl.src),
    .ext_in    (ext_in),
    .mem_rdata (mem_rdata),
    .mar_val   (mar_val),
    .pc_val    (pc_q),
    .b_val     (b_val),
    .acc_val   (acc_val),
    .bus_out   (bus_val)
  );

  fab_mem_ctl #(.ADDR_W(ADDR_W)) u_mem (
    .fetch    (ctl.fetch),
    .src      (ctl.src),
    .en_mem   (ctl.en_mem),
    .mar_val  (mar_val),
    .pc_val   (pc_q),
    .mem_addr (mem_addr),
    .mem_sel  (mem_sel),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr)
  );

endmodule

// File: rtl/fab_checker.sv
module fab_checker
  import fab_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int LOW_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CW_W-1:0]   uinst,
  input logic [ADDR_W-1:0] mar_val,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] bus_val
);

  logic       fetch;
  logic       en_pc;
  logic       en_mem;
  logic [2:0] src;
  logic [1:0] fn;

  assign fetch  = uinst[FETCH_BIT];
  assign en_pc  = uinst[EN_PC_BIT];
  assign en_mem = uinst[EN_MEM_BIT];
  assign src    = uinst[SRC_LO +: 3];
  assign fn     = uinst[FN_LO +: 2];

  a_r1_boot_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc_q == '0);

  a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    fetch |-> mem_addr == pc_q);

  a_r2_mar_addr: assert property (@(posedge clk) disable iff (rst)
    !fetch |-> mem_addr == mar_val);

  a_r4_low_mask: assert property (@(posedge clk) disable iff (rst)
    src == 3'd6 |-> bus_val[DATA_W-1:LOW_W] == '0);

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    src == 3'd7 |-> bus_val == '0);

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (en_pc && fn == 2'd1) |=> pc_q == '0);

  a_r7_step_up: assert property (@(posedge clk) disable iff (rst)
    (en_pc && fn == 2'd2) |=> pc_q == $past(pc_q) + ADDR_W'(1));

  a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
    (en_pc && fn == 2'd3) |=> pc_q == $past(pc_q) - ADDR_W'(1));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !en_pc |=> $stable(pc_q));

  a_r9_read_kinds: assert property (@(posedge clk) disable iff (rst)
    (fetch || src == 3'd1 || src == 3'd6) |-> (mem_rd && mem_sel));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r10_write_sel: assert property (@(posedge clk) disable iff (rst)
    (en_mem && !mem_rd) |-> (mem_wr && mem_sel));

endmodule

bind fetch_bus_ctrl fab_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .uinst    (uinst),
  .mar_val  (mar_val),
  .pc_q     (pc_q),
  .mem_addr (mem_addr),
  .mem_sel  (mem_sel),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .bus_val  (bus_val)
);

// File: tb/fetch_bus_ctrl_test.sv
`timescale 1ns/1ps
module fetch_bus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] uinst = '0;
  logic [11:0] ext_in = '0, mem_rdata = '0, mar_val = '0, acc_val = '0, b_val = '0;
  logic [11:0] mem_addr, bus_val;
  logic        mem_sel, mem_rd, mem_wr;

  int n_checks = 0;
  int n_fail   = 0;
  int m_pc     = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  fetch_bus_ctrl uut (
    .clk(clk), .rst(rst), .uinst(uinst), .ext_in(ext_in), .mem_rdata(mem_rdata),
    .mar_val(mar_val), .acc_val(acc_val), .b_val(b_val), .mem_addr(mem_addr),
    .mem_sel(mem_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_val(bus_val)
  );

  function automatic logic [31:0] cw(input bit fetch, input int src, input int fn,
                                     input bit pc_en, input bit mem_en, input int others);
    logic [31:0] w = '0;
    w[19] = fetch;
    w[7:5] = 3'(src);
    w[13:12] = 2'(fn);
    w[2] = pc_en;
    w[0] = mem_en;
    w[4] = others[2];
    w[3] = others[1];
    w[1] = others[0];
    return w;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_bus(input int src);
    case (src)
      0: return int'(ext_in);
      1: return int'(mem_rdata);
      2: return int'(mar_val);
      3: return m_pc;
      4: return int'(b_val);
      5: return int'(acc_val);
      6: return int'(mem_rdata) & 8'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic step(input string tag, input logic [31:0] w, input logic [11:0] e, input logic [11:0] m,
                      input logic [11:0] a, input logic [11:0] ac, input logic [11:0] bb);
    int src, fn, eb;
    bit rd, wr;
    @(negedge clk);
    uinst = w; ext_in = e; mem_rdata = m; mar_val = a; acc_val = ac; b_val = bb;
    #1;
    src = int'(w[7:5]);
    fn  = int'(w[13:12]);
    eb  = model_bus(src);
    rd  = w[19] || src == 1 || src == 6;
    wr  = w[0] && !rd;
    check(tag, "bus", int'(bus_val), eb);
    check(tag, "addr", int'(mem_addr), w[19] ? m_pc : int'(a));
    check(tag, "rd", int'(mem_rd), int'(rd));
    check(tag, "wr", int'(mem_wr), int'(wr));
    check(tag, "sel", int'(mem_sel), int'(rd || wr));
    if (w[2]) begin
      case (fn)
        0: m_pc = eb & 12'hFFF;
        1: m_pc = 0;
        2: m_pc = (m_pc + 1) & 12'hFFF;
        default: m_pc = (m_pc + 4095) & 12'hFFF;
      endcase
    end
  endtask

  task automatic read_pc(input string tag);
    step(tag, cw(0, 3, 0, 0, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
  endtask

  initial begin
    #1;
    // R1: cleared at time zero under reset, fetch addresses 0
    uinst = cw(1, 3, 0, 0, 0, 0);
    #0.5;
    check("R1", "addr_in_reset", int'(mem_addr), 0);
    check("R1", "bus_in_reset", int'(bus_val), 0);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_pc = 0;
    step("R1", cw(1, 0, 0, 0, 0, 0), 12'h0, 12'h0, 12'h777, 12'h0, 12'h0);

    // R6: every function
    step("R6", cw(0, 0, 0, 1, 0, 0), 12'h123, 12'h0, 12'h0, 12'h0, 12'h0);
    read_pc("R6");
    step("R6", cw(0, 5, 2, 1, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    read_pc("R6");
    step("R6", cw(0, 4, 3, 1, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step("R6", cw(0, 4, 3, 1, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    read_pc("R6");
    step("R6", cw(0, 1, 1, 1, 0, 0), 12'h0, 12'hFFF, 12'h0, 12'h0, 12'h0);
    read_pc("R6");

    // R7: wrap both ways
    step("R7", cw(0, 0, 0, 1, 0, 0), 12'hFFF, 12'h0, 12'h0, 12'h0, 12'h0);
    step("R7", cw(0, 0, 2, 1, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    read_pc("R7");
    step("R7", cw(0, 0, 3, 1, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    read_pc("R7");

    // R8: other enables and function field leave PC alone
    for (int k = 0; k < 4; k++)
      step("R8", cw(0, 0, k, 0, 1, 7), 12'h5A5, 12'h0, 12'h0, 12'h0, 12'h0);
    read_pc("R8");

    // R2: address selection
    step("R2", cw(1, 4, 0, 0, 0, 0), 12'h0, 12'h0, 12'h055, 12'h0, 12'h0);
    step("R2", cw(0, 4, 0, 0, 0, 0), 12'h0, 12'h0, 12'h055, 12'h0, 12'h0);

    // R3, R4, R5: every bus source
    for (int s = 0; s < 8; s++)
      step(s == 6 ? "R4" : (s == 7 ? "R5" : "R3"), cw(0, s, 0, 0, 0, 0),
           12'h111, 12'hABC, 12'h333, 12'h555, 12'h444);
    step("R4", cw(0, 6, 0, 1, 0, 0), 12'h0, 12'hF42, 12'h0, 12'h0, 12'h0);
    read_pc("R4");

    // R9, R10: strobes
    step("R9", cw(1, 5, 0, 0, 1, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step("R9", cw(0, 1, 0, 0, 1, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step("R9", cw(0, 6, 0, 0, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step("R10", cw(0, 5, 0, 0, 1, 0), 12'h0, 12'h0, 12'h0, 12'h9, 12'h0);
    step("R10", cw(0, 2, 0, 0, 0, 0), 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);

    // R1: asynchronous clear mid-run, seen before any clock edge
    step("R1", cw(0, 0, 0, 1, 0, 0), 12'h6C3, 12'h0, 12'h0, 12'h0, 12'h0);
    @(negedge clk);
    uinst = cw(0, 3, 0, 0, 0, 0);
    #0.5;
    rst = 1'b1;
    #0.5;
    check("R1", "async_clear", int'(bus_val), 0);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0;
    read_pc("R1");

    // Random control words against the model
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      int s;
      w = $urandom;
      s = int'(w[7:5]);
      step(w[2] ? (w[13:12] >= 2 ? "R7" : "R6") : (s == 6 ? "R4" : (s == 7 ? "R5" : "R3")),
           w, 12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule